// File: doc/BRIEF.md
# Memory Security Access Filter

This block protects the secure memory of a small microcontroller: flash and RAM. When reset is released, it waits a fixed number of cycles and then captures a security option byte from the nonvolatile store into a working register. Two bits of that byte decide whether the device is secured. Only one value of those bits leaves the device open.

While the device is secured, the block checks every bus access in the cycle it is made. It looks at three things: the target address, whether the code running now was fetched from secure memory, and whether the access comes from the debug port. A blocked write never reaches the memory's write enable. A blocked read returns zero in place of the memory data.

The block also gates the enable request of the on-chip debug module. It reports the key-enable bit of the option byte. It accepts a temporary-unsecure request from an external key-compare block, and that request takes effect only if key-enable is 1.

Top module: `mem_sec_filter`

## Requirements
- R1: From reset until the option capture completes, `secured_o` is 1 and `key_en_o` is 0. The capture completes on the LOAD_LAT-th rising clock edge after reset is released (LOAD_LAT = 4 by default).
- R2: After capture, if security field bits [1:0] of the captured byte equal binary 10, `secured_o` is 0.
- R3: After capture, security field values 00, 01 and 11 give `secured_o` = 1.
- R4: Secure memory is RAM (0x0080 to 0x107F) and flash (0x2000 and above). An access to any other address is never blocked.
- R5: When the latest fetch address was in secure memory, a non-debug access to secure memory is passed through.
- R6: When the device is secured and the latest fetch address was outside secure memory, an access to secure memory is blocked. `blocked_o` is 1, `mem_we_o` is 0, and `rdata_o` is 0.
- R7: When the device is secured, a debug access (`bus_dbg_i` = 1) to secure memory is blocked, whatever the fetch region is.
- R8: When the device is unsecured, no access is blocked.
- R9: `ocd_en_o` equals `ocd_en_req_i` while unsecured and is 0 while secured.
- R10: After capture, `key_en_o` equals bit 7 of the captured byte.
- R11: If key-enable is 1, `unsec_req_i` clears `secured_o` from the next cycle until reset. If key-enable is 0, the request has no effect.
- R12: The fetch region register changes only in cycles where `fetch_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nv_opt_i | input | 8 | Option byte from the nonvolatile store |
| unsec_req_i | input | 1 | Temporary-unsecure request from the key-compare block |
| fetch_i | input | 1 | The current cycle is an opcode fetch |
| fetch_addr_i | input | ADDR_W | Address of the opcode fetch |
| bus_req_i | input | 1 | A data access is valid |
| bus_we_i | input | 1 | The data access is a write |
| bus_dbg_i | input | 1 | The data access comes from the debug interface |
| bus_addr_i | input | ADDR_W | Address of the data access |
| mem_rdata_i | input | DATA_W | Raw read data from memory |
| ocd_en_req_i | input | 1 | Request to enable on-chip debug |
| mem_we_o | output | 1 | Write enable passed to memory |
| rdata_o | output | DATA_W | Filtered read data |
| blocked_o | output | 1 | The current access is blocked |
| secured_o | output | 1 | The device is secured |
| key_en_o | output | 1 | Backdoor key unlocking is permitted |
| ocd_en_o | output | 1 | On-chip debug enable |

## Verification
The following rules are checked on every cycle:
- the device stays secured until the option capture completes;
- a blocked access never drives a write and never returns nonzero data;
- debug stays off while secured;
- an unsecured device blocks nothing and stays unsecured until reset;
- the fetch region holds between fetches.

The bench scenarios cover the behaviour that depends on history or configuration: the exact capture cycle, each security encoding, the address boundaries, the key-enable gating of the unsecure request, and the fact that the fetch region, not the data address, decides the outcome.

// File: rtl/msf_pkg.sv
package msf_pkg;
  typedef struct packed {
    logic       key_en;
    logic [4:0] spare;
    logic [1:0] sec;
  } opt_t;

  localparam logic [1:0] SEC_OPEN   = 2'b10;
  localparam logic [7:0] OPT_ERASED = 8'hFF;
endpackage

// File: rtl/msf_opt_loader.sv
module msf_opt_loader #(
  parameter int unsigned LOAD_LAT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    nv_opt_i,
  output msf_pkg::opt_t opt_o,
  output logic          loaded_o
);
  localparam int unsigned CNT_W = $clog2(LOAD_LAT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      loaded_o <= 1'b0;
      opt_o    <= msf_pkg::OPT_ERASED;
    end else if (!loaded_o) begin
      if (cnt_q == CNT_W'(LOAD_LAT - 1)) begin
        loaded_o <= 1'b1;
        opt_o    <= nv_opt_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/msf_region_dec.sv
module msf_region_dec #(
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  RAM_LO   = 16'h0080,
  parameter logic [ADDR_W-1:0]  RAM_HI   = 16'h107F,
  parameter logic [ADDR_W-1:0]  FLASH_LO = 16'h2000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              secure_o
);
  // Flash runs to the top of the address space.
  assign secure_o = ((addr_i >= RAM_LO) && (addr_i <= RAM_HI)) || (addr_i >= FLASH_LO);
endmodule

// File: rtl/msf_sec_state.sv
module msf_sec_state (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  msf_pkg::opt_t opt_i,
  input  logic          loaded_i,
  input  logic          unsec_req_i,
  output logic          secured_o,
  output logic          key_en_o
);
  logic unsec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   unsec_q <= 1'b0;
    else if (loaded_i && opt_i.key_en && unsec_req_i) unsec_q <= 1'b1;
  end

  assign secured_o = !loaded_i || ((opt_i.sec != msf_pkg::SEC_OPEN) && !unsec_q);
  assign key_en_o  = loaded_i && opt_i.key_en;
endmodule

// File: rtl/msf_exec_track.sv
module msf_exec_track #(
  parameter int unsigned        ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]  RAM_LO   = 16'h0080,
  parameter logic [ADDR_W-1:0]  RAM_HI   = 16'h107F,
  parameter logic [ADDR_W-1:0]  FLASH_LO = 16'h2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              exec_sec_o
);
  logic fetch_sec;

  msf_region_dec #(
    .ADDR_W(ADDR_W), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .FLASH_LO(FLASH_LO)
  ) fetch_dec_i (
    .addr_i  (fetch_addr_i),
    .secure_o(fetch_sec)
  );

  // Out of reset, code counts as unsecured until the first fetch.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      exec_sec_o <= 1'b0;
    else if (fetch_i) exec_sec_o <= fetch_sec;
  end
endmodule

// File: rtl/msf_access_gate.sv
module msf_access_gate #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              secured_i,
  input  logic              addr_sec_i,
  input  logic              exec_sec_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              dbg_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              blocked_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  assign blocked_o = req_i && secured_i && addr_sec_i && (dbg_i || !exec_sec_i);
  assign mem_we_o  = req_i && we_i && !blocked_o;
  assign rdata_o   = blocked_o ? '0 : mem_rdata_i;
endmodule

// File: rtl/mem_sec_filter.sv
module mem_sec_filter #(
  parameter int unsigned        ADDR_W   = 16,
  parameter int unsigned        DATA_W   = 8,
  parameter int unsigned        LOAD_LAT = 4,
  parameter logic [ADDR_W-1:0]  RAM_LO   = 16'h0080,
  parameter logic [ADDR_W-1:0]  RAM_HI   = 16'h107F,
  parameter logic [ADDR_W-1:0]  FLASH_LO = 16'h2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        nv_opt_i,
  input  logic              unsec_req_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic              bus_dbg_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              ocd_en_req_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              blocked_o,
  output logic              secured_o,
  output logic              key_en_o,
  output logic              ocd_en_o
);
  msf_pkg::opt_t opt_q;
  logic          opt_loaded;
  logic          exec_sec;
  logic          addr_sec;

  msf_opt_loader #(.LOAD_LAT(LOAD_LAT)) loader_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nv_opt_i(nv_opt_i),
    .opt_o   (opt_q),
    .loaded_o(opt_loaded)
  );

  msf_sec_state state_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opt_i      (opt_q),
    .loaded_i   (opt_loaded),
    .unsec_req_i(unsec_req_i),
    .secured_o  (secured_o),
    .key_en_o   (key_en_o)
  );

  msf_exec_track #(
    .ADDR_W(ADDR_W), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .FLASH_LO(FLASH_LO)
  ) exec_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_i     (fetch_i),
    .fetch_addr_i(fetch_addr_i),
    .exec_sec_o  (exec_sec)
  );

  msf_region_dec #(
    .ADDR_W(ADDR_W), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .FLASH_LO(FLASH_LO)
  ) bus_dec_i (
    .addr_i  (bus_addr_i),
    .secure_o(addr_sec)
  );

  msf_access_gate #(.DATA_W(DATA_W)) gate_i (
    .secured_i  (secured_o),
    .addr_sec_i (addr_sec),
    .exec_sec_i (exec_sec),
    .req_i      (bus_req_i),
    .we_i       (bus_we_i),
    .dbg_i      (bus_dbg_i),
    .mem_rdata_i(mem_rdata_i),
    .blocked_o  (blocked_o),
    .mem_we_o   (mem_we_o),
    .rdata_o    (rdata_o)
  );

  assign ocd_en_o = ocd_en_req_i && !secured_o;
endmodule

// File: rtl/msf_chk.sv
module msf_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              loaded,
  input logic              exec_sec,
  input logic              fetch_i,
  input logic              bus_we_i,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              blocked_o,
  input logic              secured_o,
  input logic              key_en_o,
  input logic              ocd_en_o
);
  // R1
  secure_until_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded |-> (secured_o && !key_en_o));
  // R6
  blocked_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_o && bus_we_i) |-> !mem_we_o);
  // R6
  blocked_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_o |-> (rdata_o == '0));
  // R8
  open_no_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !secured_o |-> !blocked_o);
  // R9
  ocd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secured_o |-> !ocd_en_o);
  // R11
  unsec_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded && !secured_o) |=> !secured_o);
  // R12
  exec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_i |=> $stable(exec_sec));
endmodule

bind mem_sec_filter msf_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .loaded   (opt_loaded),
  .exec_sec (exec_sec),
  .fetch_i  (fetch_i),
  .bus_we_i (bus_we_i),
  .mem_we_o (mem_we_o),
  .rdata_o  (rdata_o),
  .blocked_o(blocked_o),
  .secured_o(secured_o),
  .key_en_o (key_en_o),
  .ocd_en_o (ocd_en_o)
);

// File: tb/mem_sec_filter_tb_top.sv
module mem_sec_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  nv_opt = 8'h00;
  logic        unsec_req = 1'b0, fetch = 1'b0, req = 1'b0, we = 1'b0, dbg = 1'b0, ocd_req = 1'b0;
  logic [15:0] fetch_addr = 16'h0, addr = 16'h0;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_we, blocked, secured, key_en, ocd_en;
  logic [7:0]  rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int   m_cnt;
  bit   m_loaded, m_unsec, m_exec;
  logic [7:0] m_opt;

  always #10 clk = ~clk;

  mem_sec_filter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .nv_opt_i(nv_opt), .unsec_req_i(unsec_req),
    .fetch_i(fetch), .fetch_addr_i(fetch_addr), .bus_req_i(req), .bus_we_i(we),
    .bus_dbg_i(dbg), .bus_addr_i(addr), .mem_rdata_i(mem_rdata), .ocd_en_req_i(ocd_req),
    .mem_we_o(mem_we), .rdata_o(rdata), .blocked_o(blocked), .secured_o(secured),
    .key_en_o(key_en), .ocd_en_o(ocd_en)
  );

  function automatic bit in_sec(logic [15:0] a);
    return (a >= 16'h0080 && a <= 16'h107F) || (a >= 16'h2000);
  endfunction

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    bit e_sec, e_blk;
    #2;
    e_sec = !m_loaded || (m_opt[1:0] != 2'b10 && !m_unsec);
    e_blk = req && e_sec && in_sec(addr) && (dbg || !m_exec);
    cmp(tag, "secured", {7'd0, secured}, {7'd0, e_sec});
    cmp(tag, "key_en",  {7'd0, key_en},  {7'd0, m_loaded && m_opt[7]});
    cmp(tag, "blocked", {7'd0, blocked}, {7'd0, e_blk});
    cmp(tag, "mem_we",  {7'd0, mem_we},  {7'd0, req && we && !e_blk});
    cmp(tag, "rdata",   rdata,           e_blk ? 8'h00 : mem_rdata);
    cmp(tag, "ocd_en",  {7'd0, ocd_en},  {7'd0, ocd_req && !e_sec});
    @(posedge clk);
    if (!m_loaded) begin
      if (m_cnt == 3) begin m_loaded = 1; m_opt = nv_opt; end
      else m_cnt++;
    end else if (unsec_req && m_opt[7]) m_unsec = 1;
    if (fetch) m_exec = in_sec(fetch_addr);
    @(negedge clk);
  endtask

  task automatic do_reset(logic [7:0] opt);
    @(negedge clk);
    rst_ni = 0; nv_opt = opt;
    m_cnt = 0; m_loaded = 0; m_unsec = 0; m_exec = 0; m_opt = 8'hFF;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic acc(logic r, logic w, logic d, logic [15:0] a, logic [7:0] rd);
    req = r; we = w; dbg = d; addr = a; mem_rdata = rd;
  endtask

  initial begin
    // Phase A: open encoding, key disabled
    do_reset(8'h02);
    acc(1, 1, 0, 16'h2000, 8'hA5); ocd_req = 1;
    step("R1"); step("R1"); step("R1"); step("R1");
    step("R2"); acc(1, 0, 1, 16'hF000, 8'h5A); step("R8");
    acc(1, 1, 0, 16'h0100, 8'h3C); step("R8"); step("R9");
    // Phase B: erased encoding 11, key disabled
    do_reset(8'h03);
    acc(0, 0, 0, 16'h0, 8'h00); repeat (4) step("R1");
    step("R3"); step("R9"); step("R10");
    fetch = 1; fetch_addr = 16'h0010; step("R6"); fetch = 0;
    acc(1, 1, 0, 16'h2000, 8'h77); step("R6");
    acc(1, 0, 0, 16'h0100, 8'h99); step("R6");
    acc(1, 0, 0, 16'h107F, 8'h11); step("R6");
    acc(1, 1, 0, 16'h0010, 8'h42); step("R4");
    acc(1, 0, 0, 16'h1800, 8'h24); step("R4");
    acc(1, 0, 0, 16'h0080, 8'h66); step("R4");
    acc(1, 0, 0, 16'h1080, 8'h67); step("R4");
    acc(1, 0, 0, 16'h1FFF, 8'h68); step("R4");
    fetch = 1; fetch_addr = 16'hE000; step("R12"); fetch = 0;
    acc(1, 1, 0, 16'h2000, 8'h81); step("R5");
    acc(1, 0, 0, 16'h0200, 8'h82); step("R5");
    acc(1, 0, 1, 16'hFFFE, 8'h83); step("R7");
    acc(1, 1, 1, 16'h0100, 8'h84); step("R7");
    fetch_addr = 16'h0020; acc(1, 0, 0, 16'h3000, 8'h85); step("R12"); step("R12");
    unsec_req = 1; step("R11"); step("R11"); unsec_req = 0; step("R11");
    // Phase C: encoding 00, key enabled
    do_reset(8'h80);
    acc(1, 0, 1, 16'h3000, 8'hC3);
    repeat (4) step("R1");
    step("R3"); step("R10");
    unsec_req = 1; step("R11"); unsec_req = 0;
    step("R11"); step("R11"); step("R8"); step("R9");
    // Phase D: encoding 01, key enabled; reset restores security
    do_reset(8'h81);
    repeat (4) step("R1");
    step("R3"); step("R10"); step("R7");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule